// File: doc/BRIEF.md
# Prioritized Trap Interrupt Controller

This block keeps the pending interrupt requests of one processor core. Requests are grouped into seven kinds, and each kind owns a 64-bit source vector. A set command and a drop command each name a kind and a bit index, and they set or reset one source bit. A flush command empties every vector at once. Alongside the vectors the block keeps a per-kind summary bit, which shows whether that kind has any source pending. Software-side logic can read any one vector through a combinational readback port.

From the registered state and two mode inputs, a hyperprivileged flag and an interrupt-enable flag, the block computes three results: whether an interrupt should be taken, which kind wins, and, when the winner is the soft kind, a 4-bit priority level. Clearing is done only with the drop and flush commands. A command whose kind or index is out of range changes nothing and raises a one-cycle error pulse.

Top module: `trap_irq_arbiter`

## Requirements
- R1: A set command (set_vld with set_kind below 7 and set_idx below 64) makes bit set_idx of that kind's vector 1 from the next clock edge, and makes the kind's summary bit (pend_sum bit = kind number) 1. The vector is visible on rd_vec when rd_kind selects the kind.
- R2: A drop command resets the addressed bit from the next edge. The kind's summary bit goes to 0 only when the whole 64-bit vector has become zero.
- R3: A flush command (flush = 1) zeroes all seven vectors and pend_sum on the next edge. It takes precedence over a set or drop issued in the same cycle.
- R4: When a set and a drop address the same kind and bit in the same cycle, the bit ends up 1. A set and a drop on different bits of one kind both take effect.
- R5: A set or drop with kind 7 or index 64 or above leaves all vectors and pend_sum unchanged, and it drives cmd_err to 1 for exactly the cycle after the command. cmd_err is 0 otherwise. rd_vec returns 0 for rd_kind 7.
- R6: When pend_sum is zero, take_irq is 0, whatever hyper_mode and irq_en are.
- R7: With hyper_mode = 1, only the hyper-timer kind (1) and then the vector kind (2) can win, and only when irq_en = 1. All other kinds are masked.
- R8: With hyper_mode = 0, the trap-level-zero kind (0), then the hyper-timer kind (1), then the vector kind (2) win in that order, whatever irq_en is.
- R9: With hyper_mode = 0 and irq_en = 1, the next kinds in priority order are CPU mondo (3), device mondo (4), soft (5) and resumable error (6).
- R10: soft_lvl is 14 when bit 16 or bit 0 of the soft vector is set. Otherwise it is the index of the highest set bit among bits 15 down to 1, and 0 when none of those bits is set.
- R11: soft_lvl is 0 whenever the winner is not the soft kind, and win_kind is 0 whenever take_irq is 0.
- R12: After reset, every vector, pend_sum, take_irq and cmd_err are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| set_vld | input | 1 | Set command strobe |
| set_kind | input | 3 | Kind addressed by the set command |
| set_idx | input | 7 | Bit index addressed by the set command |
| drop_vld | input | 1 | Drop command strobe |
| drop_kind | input | 3 | Kind addressed by the drop command |
| drop_idx | input | 7 | Bit index addressed by the drop command |
| flush | input | 1 | Clears every vector and the summary |
| rd_kind | input | 3 | Kind selected for readback |
| rd_vec | output | 64 | Source vector of the selected kind |
| pend_sum | output | 7 | Per-kind summary bits |
| hyper_mode | input | 1 | Core runs in hyperprivileged mode |
| irq_en | input | 1 | Interrupt-enable flag of the core |
| take_irq | output | 1 | An interrupt should be taken |
| win_kind | output | 3 | Winning kind (0..6) |
| soft_lvl | output | 4 | Soft interrupt level, valid when win_kind is 5 |
| cmd_err | output | 1 | One-cycle pulse after an out-of-range command |

## Verification
A wrong source bit shows up on rd_vec during the cycle right after the faulty edge. It also shows up in pend_sum, and through the arbiter in take_irq and win_kind as soon as the mode inputs make that kind eligible. A summary bit that falls too early or stays up too long changes the winner during the same cycle, even while the vector still reads back correctly. The bench therefore checks pend_sum and the arbiter outputs directly after every command sequence, and for every mode pair. A soft encoder fault is visible only while the soft kind wins, so the level sweep runs with every other kind empty.

// File: rtl/tia_pkg.sv
package tia_pkg;
  localparam int NUM_KINDS = 7;
  localparam int KIND_W    = 3;
  localparam int LVL_W     = 4;

  localparam int K_TLZ    = 0;
  localparam int K_HTMR   = 1;
  localparam int K_IVEC   = 2;
  localparam int K_CMONDO = 3;
  localparam int K_DMONDO = 4;
  localparam int K_SOFT   = 5;
  localparam int K_RERR   = 6;

  localparam int SOFT_FORCE_LVL = 14;
  localparam int SOFT_ALT_BIT   = 16;
  localparam int SOFT_SCAN_HI   = 15;
endpackage

// File: rtl/tia_cmd_decode.sv
module tia_cmd_decode
  import tia_pkg::*;
#(
  parameter int SRC_W = 64,
  localparam int IDX_W    = $clog2(SRC_W),
  localparam int IDX_IN_W = IDX_W + 1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 set_vld,
  input  logic [KIND_W-1:0]                    set_kind,
  input  logic [IDX_IN_W-1:0]                  set_idx,
  input  logic                                 drop_vld,
  input  logic [KIND_W-1:0]                    drop_kind,
  input  logic [IDX_IN_W-1:0]                  drop_idx,
  output logic [NUM_KINDS-1:0][SRC_W-1:0]      set_mask,
  output logic [NUM_KINDS-1:0][SRC_W-1:0]      drop_mask,
  output logic                                 cmd_err
);
  logic set_ok, drop_ok, set_bad, drop_bad;
  logic err_d, err_q;
  logic [SRC_W-1:0] set_bit, drop_bit;

  always_comb begin
    set_ok   = (int'(set_kind) < NUM_KINDS) && (int'(set_idx) < SRC_W);
    drop_ok  = (int'(drop_kind) < NUM_KINDS) && (int'(drop_idx) < SRC_W);
    set_bad  = set_vld && !set_ok;
    drop_bad = drop_vld && !drop_ok;
    set_bit  = SRC_W'(1) << set_idx[IDX_W-1:0];
    drop_bit = SRC_W'(1) << drop_idx[IDX_W-1:0];
    err_d    = set_bad || drop_bad;
  end

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    always_comb begin
      set_mask[k]  = (set_vld && set_ok && (int'(set_kind) == k)) ? set_bit : '0;
      drop_mask[k] = (drop_vld && drop_ok && (int'(drop_kind) == k)) ? drop_bit : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign cmd_err = err_q;

  assert_err_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vld && int'(set_kind) >= NUM_KINDS) |=> cmd_err);
  assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_vld && !drop_vld) |=> !cmd_err);
endmodule

// File: rtl/tia_src_vec.sv
module tia_src_vec #(
  parameter int SRC_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [SRC_W-1:0] set_mask,
  input  logic [SRC_W-1:0] drop_mask,
  output logic [SRC_W-1:0] vec_q,
  output logic             any_q
);
  logic [SRC_W-1:0] vec_d;
  logic             any_d;
  logic             upd_en;

  always_comb begin
    upd_en = flush || (|set_mask) || (|drop_mask);
    if (flush) begin
      vec_d = '0;
      any_d = 1'b0;
    end else begin
      vec_d = (vec_q & ~drop_mask) | set_mask;
      any_d = (|set_mask) ? 1'b1 : (|vec_d);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      any_q <= 1'b0;
    end else if (upd_en) begin
      vec_q <= vec_d;
      any_q <= any_d;
    end
  end

  assert_set_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && |set_mask) |=> |(vec_q & $past(set_mask)));
  assert_drop_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && |(drop_mask & ~set_mask)) |=> ((vec_q & $past(drop_mask & ~set_mask)) == '0));
  assert_summary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    any_q == (|vec_q));
  assert_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vec_q == '0 && !any_q));
endmodule

// File: rtl/tia_soft_level.sv
module tia_soft_level
  import tia_pkg::*;
#(
  parameter int SRC_W = 64
) (
  input  logic [SRC_W-1:0] soft_vec,
  output logic [LVL_W-1:0] level
);
  always_comb begin
    level = '0;
    for (int i = 1; i <= SOFT_SCAN_HI; i++) begin
      if (soft_vec[i]) level = LVL_W'(i);
    end
    if (soft_vec[0] || soft_vec[SOFT_ALT_BIT]) level = LVL_W'(SOFT_FORCE_LVL);
  end
endmodule

// File: rtl/tia_arbiter.sv
module tia_arbiter
  import tia_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_KINDS-1:0] pend,
  input  logic                 hyper_mode,
  input  logic                 irq_en,
  input  logic [LVL_W-1:0]     soft_raw,
  output logic                 take_irq,
  output logic [KIND_W-1:0]    win_kind,
  output logic [LVL_W-1:0]     soft_lvl
);
  logic [NUM_KINDS-1:0] elig;

  always_comb begin
    elig = '0;
    if (hyper_mode) begin
      elig[K_HTMR] = pend[K_HTMR] && irq_en;
      elig[K_IVEC] = pend[K_IVEC] && irq_en;
    end else begin
      elig[K_TLZ]    = pend[K_TLZ];
      elig[K_HTMR]   = pend[K_HTMR];
      elig[K_IVEC]   = pend[K_IVEC];
      elig[K_CMONDO] = pend[K_CMONDO] && irq_en;
      elig[K_DMONDO] = pend[K_DMONDO] && irq_en;
      elig[K_SOFT]   = pend[K_SOFT] && irq_en;
      elig[K_RERR]   = pend[K_RERR] && irq_en;
    end
  end

  always_comb begin
    take_irq = 1'b0;
    win_kind = '0;
    for (int k = NUM_KINDS - 1; k >= 0; k--) begin
      if (elig[k]) begin
        take_irq = 1'b1;
        win_kind = KIND_W'(k);
      end
    end
    soft_lvl = (take_irq && int'(win_kind) == K_SOFT) ? soft_raw : '0;
  end

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !take_irq);
  assert_hyper_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hyper_mode && take_irq) |-> (irq_en && (int'(win_kind) == K_HTMR || int'(win_kind) == K_IVEC)));
  assert_top_three_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hyper_mode && pend[K_TLZ]) |-> (take_irq && win_kind == '0));
  assert_masked_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && take_irq) |-> (int'(win_kind) <= K_IVEC));
  assert_level_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(win_kind) != K_SOFT || !take_irq) |-> (soft_lvl == '0));
endmodule

// File: rtl/trap_irq_arbiter.sv
module trap_irq_arbiter
  import tia_pkg::*;
#(
  parameter int SRC_W = 64,
  localparam int IDX_W    = $clog2(SRC_W),
  localparam int IDX_IN_W = IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_vld,
  input  logic [KIND_W-1:0]    set_kind,
  input  logic [IDX_IN_W-1:0]  set_idx,
  input  logic                 drop_vld,
  input  logic [KIND_W-1:0]    drop_kind,
  input  logic [IDX_IN_W-1:0]  drop_idx,
  input  logic                 flush,
  input  logic [KIND_W-1:0]    rd_kind,
  output logic [SRC_W-1:0]     rd_vec,
  output logic [NUM_KINDS-1:0] pend_sum,
  input  logic                 hyper_mode,
  input  logic                 irq_en,
  output logic                 take_irq,
  output logic [KIND_W-1:0]    win_kind,
  output logic [LVL_W-1:0]     soft_lvl,
  output logic                 cmd_err
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_KINDS-1:0][SRC_W-1:0] set_mask, drop_mask, vec_q;
  logic [NUM_KINDS-1:0]            any_q;
  logic [LVL_W-1:0]                soft_raw;

  tia_cmd_decode #(.SRC_W(SRC_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .set_vld   (set_vld),
    .set_kind  (set_kind),
    .set_idx   (set_idx),
    .drop_vld  (drop_vld),
    .drop_kind (drop_kind),
    .drop_idx  (drop_idx),
    .set_mask  (set_mask),
    .drop_mask (drop_mask),
    .cmd_err   (cmd_err)
  );

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_vec
    tia_src_vec #(.SRC_W(SRC_W)) u_vec (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .flush     (flush),
      .set_mask  (set_mask[k]),
      .drop_mask (drop_mask[k]),
      .vec_q     (vec_q[k]),
      .any_q     (any_q[k])
    );
  end

  assign pend_sum = any_q;

  always_comb begin
    rd_vec = '0;
    for (int k = 0; k < NUM_KINDS; k++) begin
      if (int'(rd_kind) == k) rd_vec = vec_q[k];
    end
  end

  tia_soft_level #(.SRC_W(SRC_W)) u_lvl (
    .soft_vec (vec_q[K_SOFT]),
    .level    (soft_raw)
  );

  tia_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .pend       (any_q),
    .hyper_mode (hyper_mode),
    .irq_en     (irq_en),
    .soft_raw   (soft_raw),
    .take_irq   (take_irq),
    .win_kind   (win_kind),
    .soft_lvl   (soft_lvl)
  );

  assert_reset_state_R12: assert property (@(posedge clk)
    (!rst_int_n) |-> (pend_sum == '0 && !cmd_err));
endmodule

// File: tb/trap_irq_arbiter_test.sv
module trap_irq_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        set_vld = 1'b0, drop_vld = 1'b0, flush = 1'b0;
  logic [2:0]  set_kind = '0, drop_kind = '0, rd_kind = '0;
  logic [6:0]  set_idx = '0, drop_idx = '0;
  logic        hyper_mode = 1'b0, irq_en = 1'b0;
  logic [63:0] rd_vec;
  logic [6:0]  pend_sum;
  logic        take_irq, cmd_err;
  logic [2:0]  win_kind;
  logic [3:0]  soft_lvl;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  trap_irq_arbiter uut (
    .clk(clk), .rst_n(rst_n),
    .set_vld(set_vld), .set_kind(set_kind), .set_idx(set_idx),
    .drop_vld(drop_vld), .drop_kind(drop_kind), .drop_idx(drop_idx),
    .flush(flush), .rd_kind(rd_kind), .rd_vec(rd_vec), .pend_sum(pend_sum),
    .hyper_mode(hyper_mode), .irq_en(irq_en), .take_irq(take_irq),
    .win_kind(win_kind), .soft_lvl(soft_lvl), .cmd_err(cmd_err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    set_vld = 0; drop_vld = 0; flush = 0;
  endtask

  task automatic cyc(input bit sv, input int sk, input int si,
                     input bit dv, input int dk, input int di, input bit fl);
    @(negedge clk);
    set_vld = sv; set_kind = 3'(sk); set_idx = 7'(si);
    drop_vld = dv; drop_kind = 3'(dk); drop_idx = 7'(di);
    flush = fl;
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic do_set(input int k, input int i);
    cyc(1, k, i, 0, 0, 0, 0);
  endtask
  task automatic do_drop(input int k, input int i);
    cyc(0, 0, 0, 1, k, i, 0);
  endtask
  task automatic do_flush();
    cyc(0, 0, 0, 0, 0, 0, 1);
  endtask

  function automatic int exp_level(input logic [63:0] v);
    int lv = 0;
    if (v[0] || v[16]) return 14;
    for (int b = 15; b >= 1; b--) if (v[b] && lv == 0) lv = b;
    return lv;
  endfunction

  function automatic int exp_winner(input logic [6:0] p, input bit hp, input bit en);
    if (hp) begin
      if (!en) return -1;
      if (p[1]) return 1;
      if (p[2]) return 2;
      return -1;
    end
    for (int k = 0; k < 7; k++) if (p[k] && (k < 3 || en)) return k;
    return -1;
  endfunction

  task automatic check_arb(input logic [6:0] p, input logic [63:0] sv, input string tag);
    for (int m = 0; m < 4; m++) begin
      int w;
      hyper_mode = m[1]; irq_en = m[0];
      #1;
      w = exp_winner(p, m[1], m[0]);
      chk(take_irq == (w >= 0), tag, 64'(take_irq), 64'(w >= 0));
      chk(win_kind == 3'((w >= 0) ? w : 0), tag, 64'(win_kind), 64'((w >= 0) ? w : 0));
      chk(soft_lvl == 4'((w == 5) ? exp_level(sv) : 0), "R11/R10 level",
          64'(soft_lvl), 64'((w == 5) ? exp_level(sv) : 0));
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    for (int k = 0; k < 8; k++) begin
      rd_kind = 3'(k); #1;
      chk(rd_vec == 0, "R12 vec", rd_vec, 0);
    end
    chk(pend_sum == 0, "R12 sum", 64'(pend_sum), 0);
    chk(take_irq == 0, "R12 take", 64'(take_irq), 0);
    chk(cmd_err == 0, "R12 err", 64'(cmd_err), 0);

    // R1 set sweep over every kind and index
    for (int k = 0; k < 7; k++) begin
      for (int i = 0; i < 64; i++) begin
        do_flush();
        do_set(k, i);
        rd_kind = 3'(k); #1;
        chk(rd_vec == (64'd1 << i), "R1 vec", rd_vec, 64'd1 << i);
        chk(pend_sum == (7'd1 << k), "R1 sum", 64'(pend_sum), 64'(7'd1 << k));
      end
    end

    // R2 drop: summary stays until the vector is empty
    do_flush();
    do_set(4, 3); do_set(4, 60);
    do_drop(4, 3);
    rd_kind = 3'd4; #1;
    chk(rd_vec == (64'd1 << 60), "R2 partial vec", rd_vec, 64'd1 << 60);
    chk(pend_sum == 7'b0010000, "R2 sum held", 64'(pend_sum), 64'h10);
    do_drop(4, 60);
    chk(rd_vec == 0, "R2 empty vec", rd_vec, 0);
    chk(pend_sum == 0, "R2 sum drop", 64'(pend_sum), 0);
    do_drop(4, 9);
    chk(pend_sum == 0, "R2 drop empty", 64'(pend_sum), 0);

    // R3 flush over everything and against a same-cycle set
    for (int k = 0; k < 7; k++) do_set(k, k + 20);
    chk(pend_sum == 7'h7f, "R3 prefill", 64'(pend_sum), 64'h7f);
    cyc(1, 2, 8, 1, 0, 20, 1);
    chk(pend_sum == 0, "R3 flush sum", 64'(pend_sum), 0);
    for (int k = 0; k < 7; k++) begin
      rd_kind = 3'(k); #1;
      chk(rd_vec == 0, "R3 flush vec", rd_vec, 0);
    end

    // R4 same-bit set and drop, and different bits
    cyc(1, 3, 10, 1, 3, 10, 0);
    rd_kind = 3'd3; #1;
    chk(rd_vec == (64'd1 << 10), "R4 set wins", rd_vec, 64'd1 << 10);
    do_set(3, 40);
    cyc(1, 3, 5, 1, 3, 40, 0);
    chk(rd_vec == ((64'd1 << 10) | (64'd1 << 5)), "R4 both act", rd_vec,
        (64'd1 << 10) | (64'd1 << 5));

    // R5 out-of-range commands
    do_flush();
    do_set(1, 7);
    cyc(1, 7, 3, 0, 0, 0, 0);
    chk(cmd_err == 1, "R5 err kind", 64'(cmd_err), 1);
    chk(pend_sum == 7'b0000010, "R5 sum kept", 64'(pend_sum), 2);
    rd_kind = 3'd7; #1;
    chk(rd_vec == 0, "R5 rd kind7", rd_vec, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk(cmd_err == 0, "R5 err pulse end", 64'(cmd_err), 0);
    cyc(1, 2, 64, 0, 0, 0, 0);
    chk(cmd_err == 1, "R5 err idx", 64'(cmd_err), 1);
    cyc(0, 0, 0, 1, 1, 71, 0);
    chk(cmd_err == 1, "R5 err drop idx", 64'(cmd_err), 1);
    rd_kind = 3'd1; #1;
    chk(rd_vec == (64'd1 << 7), "R5 vec kept", rd_vec, 64'd1 << 7);
    chk(pend_sum == 7'b0000010, "R5 sum unchanged", 64'(pend_sum), 2);
    cyc(0, 0, 0, 1, 7, 1, 0);
    chk(cmd_err == 1, "R5 err drop kind", 64'(cmd_err), 1);
    do_set(0, 0);
    chk(cmd_err == 0, "R5 valid no err", 64'(cmd_err), 0);

    // R6..R9, R11: every subset of pending kinds under every mode
    for (int s = 0; s < 128; s++) begin
      logic [63:0] sv;
      sv = '0;
      do_flush();
      for (int k = 0; k < 7; k++) begin
        if (s[k]) begin
          do_set(k, (k * 9 + s) % 64);
          if (k == 5) sv = 64'd1 << ((k * 9 + s) % 64);
        end
      end
      chk(pend_sum == 7'(s), "R1 subset sum", 64'(pend_sum), 64'(s));
      check_arb(7'(s), sv, (s == 0) ? "R6 idle" : "R7/R8/R9 winner");
    end

    // R10 soft level: single bits and pairs, soft kind alone
    for (int i = 0; i < 64; i++) begin
      int js [4] = '{0, 16, 5, 40};
      for (int q = 0; q < 5; q++) begin
        logic [63:0] sv;
        do_flush();
        do_set(5, i);
        sv = 64'd1 << i;
        if (q < 4) begin
          do_set(5, js[q]);
          sv = sv | (64'd1 << js[q]);
        end
        hyper_mode = 0; irq_en = 1; #1;
        chk(take_irq == 1 && win_kind == 3'd5, "R10 soft wins", 64'(win_kind), 5);
        chk(soft_lvl == 4'(exp_level(sv)), "R10 level", 64'(soft_lvl), 64'(exp_level(sv)));
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule